// File: doc/BRIEF.md
# Display RAM Loader with Subaddressing

This block takes display data bytes, one at a time, and scatters their bits into a 40-word, 4-bit-wide display memory through a masked write port. How a byte is spread depends on the drive mode: one, two, three or four bits land in each word, so a byte covers eight, four, three or two consecutive words. An internal pointer names the word being written. It advances by one word per cycle and wraps after the last word.

A small subaddress counter sits alongside the pointer. It is compared with a 3-bit strap value, and memory is written only when the two agree. When they differ, the pointer still walks as if the bits had been stored. Each time the pointer wraps, the counter steps by one. This lets several chained loaders listen to one byte stream: each stores only the slice that belongs to it. The wrap can occur partway through a byte.

For the two low multiplex modes, an alternate bank puts the bits into the upper half of each word instead of the lower half. The block raises a busy flag while it writes out a byte, so upstream logic can hold off the next byte. The pointer and the counter are loaded from outside while the block is idle.

Top module: `disp_ram_loader`

## Requirements
- R1: Out of reset, busy_o, wr_en_o and wr_mask_o are low, and the pointer and subaddress counter are zero, so the first byte accepted with hw_sub_i = 0 is stored starting at word 0.
- R2: In mode 0 (static), a byte is written over 8 consecutive words with one bit each. The byte's MSB goes first, into lane 0 of the first word. The pointer ends 8 words further on.
- R3: In mode 1 (two-way multiplex), a byte covers 4 words with two bits each. Byte bit 7 goes to lane 0 and bit 6 to lane 1 of the first word, and so on. The pointer ends 4 words further on.
- R4: In mode 2 (three-way multiplex), a byte covers 3 words. The first two words get lanes 0 to 2 from the byte's bits 7..5 and 4..2. The third word gets lanes 0 and 1 from bits 1..0, and its lane 2 mask bit stays low so that bit is not written. The pointer ends 3 words further on.
- R5: In mode 3 (four-way multiplex), a byte covers 2 words with four bits each, taken MSB first from lane 0 upward. The pointer ends 2 words further on.
- R6: A word is written (wr_en_o high) only when the subaddress counter equals hw_sub_i. Otherwise no write is issued, but the pointer advances exactly as for a stored byte.
- R7: After word 39 the pointer goes to word 0 and the subaddress counter increments, wrapping modulo 8. This happens on the exact word step, even in the middle of a byte.
- R8: With bank_i high when a byte is accepted, mode 0 writes lane 2 instead of lane 0, and mode 1 writes lanes 2 and 3 instead of lanes 0 and 1. In modes 2 and 3, bank_i has no effect.
- R9: A byte is accepted when byte_vld_i is high and busy_o is low. busy_o then stays high for exactly as many cycles as the byte has words, with one word written per busy cycle. A byte_vld_i pulse while busy is ignored.
- R10: An idle-cycle ptr_ld_i loads the pointer from ptr_val_i when the value is below 40. A value of 40 or more is ignored. sub_ld_i loads the subaddress counter.
- R11: Pointer and subaddress loads that arrive while busy_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Display byte offered |
| byte_i | input | 8 | Display byte |
| mode_i | input | 2 | Drive mode: 0 static, 1 two-way, 2 three-way, 3 four-way |
| bank_i | input | 1 | Alternate input bank for modes 0 and 1 |
| hw_sub_i | input | 3 | Strapped subaddress of this device |
| ptr_ld_i | input | 1 | Load the data pointer (idle only) |
| ptr_val_i | input | 6 | Pointer load value |
| sub_ld_i | input | 1 | Load the subaddress counter (idle only) |
| sub_val_i | input | 3 | Subaddress load value |
| wr_en_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 6 | Word address of the write |
| wr_data_o | output | 4 | Write data, zero outside the mask |
| wr_mask_o | output | 4 | Per-lane write mask |
| busy_o | output | 1 | A byte is being written out |

## Verification
A pointer that is off by one, or that wraps at the wrong word, moves every later write, and this is visible on wr_addr_o at the very next stored word. A subaddress counter that drifts shows up as writes that are missing or extra, from the first word after the drift. Such writes are caught by the scoreboard, either as an unexpected pop or as a queue that is left non-empty. Wrong lane mapping or a wrong bank choice appears at once in wr_mask_o and wr_data_o for the current word. A wrong step count appears as a busy period of the wrong length for that same byte.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

   typedef enum logic [1:0] {
      MODE_STATIC = 2'd0,
      MODE_MUX2   = 2'd1,
      MODE_MUX3   = 2'd2,
      MODE_MUX4   = 2'd3
   } drive_mode_e;

   // memory lanes per word; one lane per backplane phase
   localparam int unsigned LANES = 4;

   // bits placed into each word in a given mode
   function automatic int unsigned lanes_used(drive_mode_e m);
      return int'(m) + 1;
   endfunction

   // number of words one byte occupies
   function automatic int unsigned words_per_byte(drive_mode_e m, int unsigned byte_w);
      int unsigned k;
      k = lanes_used(m);
      return (byte_w + k - 1) / k;
   endfunction

   // alternate bank only exists where half the lanes are free
   function automatic logic bank_capable(drive_mode_e m);
      return (m == MODE_STATIC) || (m == MODE_MUX2);
   endfunction

endpackage

// File: rtl/ldr_seq.sv
module ldr_seq
   import ldr_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned SW    = $clog2(BYTE_W + 1)
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  drive_mode_e       mode_i,
   input  logic              bank_i,
   output logic              busy_o,
   output logic [SW-1:0]     step_o,
   output logic [BYTE_W-1:0] byte_o,
   output drive_mode_e       mode_o,
   output logic              bank_o
);

   logic              busy_q;
   logic [SW-1:0]     step_q;
   logic [BYTE_W-1:0] byte_q;
   drive_mode_e       mode_q;
   logic              bank_q;
   logic              accept;
   logic              last_step;
   logic [SW-1:0]     final_step;

   assign accept     = start_i && !busy_q;
   assign final_step = SW'(words_per_byte(mode_q, BYTE_W) - 1);
   assign last_step  = (step_q == final_step);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= 1'b0;
         step_q <= '0;
         byte_q <= '0;
         mode_q <= MODE_MUX4;
         bank_q <= 1'b0;
      end else if (accept) begin
         busy_q <= 1'b1;
         step_q <= '0;
         byte_q <= byte_i;
         mode_q <= mode_i;
         bank_q <= bank_i;
      end else if (busy_q) begin
         if (last_step) begin
            busy_q <= 1'b0;
            step_q <= '0;
         end else begin
            step_q <= step_q + 1'b1;
         end
      end
   end

   assign busy_o = busy_q;
   assign step_o = step_q;
   assign byte_o = byte_q;
   assign mode_o = mode_q;
   assign bank_o = bank_q;

endmodule

// File: rtl/ldr_ptr.sv
module ldr_ptr #(
   parameter int unsigned DEPTH = 40,
   parameter int unsigned SUB_W = 3,
   localparam int unsigned AW   = $clog2(DEPTH)
)(
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             busy_i,
   input  logic             ptr_ld_i,
   input  logic [AW-1:0]    ptr_val_i,
   input  logic             sub_ld_i,
   input  logic [SUB_W-1:0] sub_val_i,
   output logic [AW-1:0]    ptr_o,
   output logic [SUB_W-1:0] sub_o
);

   logic [AW-1:0]    ptr_q;
   logic [SUB_W-1:0] sub_q;
   logic             at_end;
   logic [AW-1:0]    ptr_next;
   logic             load_ok;

   // wrap detection: free-running for power-of-two depths, compare otherwise
   if ((1 << AW) == DEPTH) begin : g_pow2
      assign at_end   = &ptr_q;
      assign ptr_next = ptr_q + 1'b1;
      assign load_ok  = 1'b1;
   end else begin : g_cmp
      assign at_end   = (ptr_q == AW'(DEPTH - 1));
      assign ptr_next = at_end ? '0 : ptr_q + 1'b1;
      assign load_ok  = (ptr_val_i < AW'(DEPTH));
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ptr_q <= '0;
         sub_q <= '0;
      end else if (busy_i) begin
         ptr_q <= ptr_next;
         if (at_end) sub_q <= sub_q + 1'b1;
      end else begin
         if (ptr_ld_i && load_ok) ptr_q <= ptr_val_i;
         if (sub_ld_i)            sub_q <= sub_val_i;
      end
   end

   assign ptr_o = ptr_q;
   assign sub_o = sub_q;

endmodule

// File: rtl/ldr_map.sv
module ldr_map
   import ldr_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   localparam int unsigned SW    = $clog2(BYTE_W + 1),
   localparam int unsigned BIW   = $clog2(BYTE_W)
)(
   input  logic [BYTE_W-1:0] byte_i,
   input  drive_mode_e       mode_i,
   input  logic              bank_i,
   input  logic [SW-1:0]     step_i,
   output logic [LANES-1:0]  data_o,
   output logic [LANES-1:0]  mask_o
);

   int unsigned base;
   int unsigned k;

   assign k    = lanes_used(mode_i);
   assign base = (bank_i && bank_capable(mode_i)) ? LANES / 2 : 0;

   for (genvar L = 0; L < LANES; L++) begin : g_lane
      logic           hit;
      int             rel;
      int             idx;
      logic [BIW-1:0] sel;

      always_comb begin
         rel = L - int'(base);
         idx = int'(step_i) * int'(k) + rel;
         hit = (rel >= 0) && (rel < int'(k)) && (idx < int'(BYTE_W));
         sel = hit ? BIW'(int'(BYTE_W) - 1 - idx) : '0;
      end

      assign mask_o[L] = hit;
      assign data_o[L] = hit & byte_i[sel];
   end

endmodule

// File: rtl/disp_ram_loader.sv
module disp_ram_loader
   import ldr_pkg::*;
#(
   parameter int unsigned DEPTH  = 40,
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned SUB_W  = 3,
   localparam int unsigned AW    = $clog2(DEPTH),
   localparam int unsigned SW    = $clog2(BYTE_W + 1)
)(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              byte_vld_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic [1:0]        mode_i,
   input  logic              bank_i,
   input  logic [SUB_W-1:0]  hw_sub_i,
   input  logic              ptr_ld_i,
   input  logic [AW-1:0]     ptr_val_i,
   input  logic              sub_ld_i,
   input  logic [SUB_W-1:0]  sub_val_i,
   output logic              wr_en_o,
   output logic [AW-1:0]     wr_addr_o,
   output logic [LANES-1:0]  wr_data_o,
   output logic [LANES-1:0]  wr_mask_o,
   output logic              busy_o
);

   if (BYTE_W < LANES) begin : g_bad_byte
      $error("disp_ram_loader: BYTE_W must be at least the lane count");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("disp_ram_loader: DEPTH must be at least 2");
   end
   if (SUB_W < 1) begin : g_bad_sub
      $error("disp_ram_loader: SUB_W must be at least 1");
   end

   logic              busy_w;
   logic [SW-1:0]     step_w;
   logic [BYTE_W-1:0] byte_w;
   drive_mode_e       mode_w;
   logic              bank_w;
   logic [AW-1:0]     ptr_w;
   logic [SUB_W-1:0]  sub_w;
   logic [LANES-1:0]  lane_data;
   logic [LANES-1:0]  lane_mask;
   logic              sub_match;

   ldr_seq #(.BYTE_W(BYTE_W)) seq_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .start_i(byte_vld_i),
      .byte_i (byte_i),
      .mode_i (drive_mode_e'(mode_i)),
      .bank_i (bank_i),
      .busy_o (busy_w),
      .step_o (step_w),
      .byte_o (byte_w),
      .mode_o (mode_w),
      .bank_o (bank_w)
   );

   ldr_ptr #(.DEPTH(DEPTH), .SUB_W(SUB_W)) ptr_i (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .busy_i   (busy_w),
      .ptr_ld_i (ptr_ld_i),
      .ptr_val_i(ptr_val_i),
      .sub_ld_i (sub_ld_i),
      .sub_val_i(sub_val_i),
      .ptr_o    (ptr_w),
      .sub_o    (sub_w)
   );

   ldr_map #(.BYTE_W(BYTE_W)) map_i (
      .byte_i(byte_w),
      .mode_i(mode_w),
      .bank_i(bank_w),
      .step_i(step_w),
      .data_o(lane_data),
      .mask_o(lane_mask)
   );

   assign sub_match = (sub_w == hw_sub_i);
   assign wr_en_o   = busy_w && sub_match;
   assign wr_addr_o = ptr_w;
   assign wr_mask_o = wr_en_o ? lane_mask : '0;
   assign wr_data_o = lane_data & wr_mask_o;
   assign busy_o    = busy_w;

endmodule

// File: rtl/ldr_chk.sv
module ldr_chk
   import ldr_pkg::*;
#(
   parameter int unsigned DEPTH = 40,
   parameter int unsigned SUB_W = 3,
   parameter int unsigned AW    = 6
)(
   input logic              clk_i,
   input logic              rst_ni,
   input logic              busy_i,
   input logic              wr_en_i,
   input logic [AW-1:0]     wr_addr_i,
   input logic [LANES-1:0]  wr_mask_i,
   input logic [SUB_W-1:0]  sub_i,
   input logic [SUB_W-1:0]  hw_sub_i,
   input drive_mode_e       mode_i,
   input logic              bank_i
);

   AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_i |-> (!wr_en_i && wr_mask_i == '0));                              // R9

   AST_WRITE_ONLY_ON_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |-> (sub_i == hw_sub_i));                                         // R6

   AST_ADDR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i |-> (wr_addr_i < AW'(DEPTH)));                                     // R7

   AST_ADDR_STEPS_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && $past(busy_i)) |->
         (wr_addr_i == (($past(wr_addr_i) == AW'(DEPTH - 1)) ? '0 : $past(wr_addr_i) + 1'b1))); // R7

   AST_SUB_STEPS_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && $past(busy_i) && $past(wr_addr_i) == AW'(DEPTH - 1)) |->
         (sub_i == SUB_W'($past(sub_i) + 1'b1)));                              // R7

   AST_SUB_HELD_MID_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && $past(busy_i) && $past(wr_addr_i) != AW'(DEPTH - 1)) |->
         $stable(sub_i));                                                       // R6

   AST_STATIC_SINGLE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && mode_i == MODE_STATIC) |-> ($countones(wr_mask_i) == 1));     // R2

   AST_BANK_UPPER_HALF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && bank_i && bank_capable(mode_i)) |-> (wr_mask_i[1:0] == 2'b00)); // R8

   AST_MODE_HELD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_i && $past(busy_i)) |-> ($stable(mode_i) && $stable(bank_i)));     // R11

endmodule

bind disp_ram_loader ldr_chk #(.DEPTH(DEPTH), .SUB_W(SUB_W), .AW(AW)) chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .busy_i   (busy_w),
   .wr_en_i  (wr_en_o),
   .wr_addr_i(wr_addr_o),
   .wr_mask_i(wr_mask_o),
   .sub_i    (sub_w),
   .hw_sub_i (hw_sub_i),
   .mode_i   (mode_w),
   .bank_i   (bank_w)
);

// File: tb/disp_ram_loader_tb_top.sv
module disp_ram_loader_tb_top;

   localparam time CLK_PERIOD = 10ns;
   localparam int  DEPTH      = 40;

   typedef struct packed {
      logic [5:0] addr;
      logic [3:0] data;
      logic [3:0] mask;
   } wr_item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       byte_vld = 1'b0;
   logic [7:0] byte_d = '0;
   logic [1:0] mode = '0;
   logic       bank = 1'b0;
   logic [2:0] hw_sub = '0;
   logic       ptr_ld = 1'b0;
   logic [5:0] ptr_val = '0;
   logic       sub_ld = 1'b0;
   logic [2:0] sub_val = '0;
   logic       wr_en;
   logic [5:0] wr_addr;
   logic [3:0] wr_data;
   logic [3:0] wr_mask;
   logic       busy;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   wr_item_t exp_q[$];
   int m_ptr = 0;
   int m_sub = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   disp_ram_loader dut_i (
      .clk_i(clk), .rst_ni(rst_n), .byte_vld_i(byte_vld), .byte_i(byte_d),
      .mode_i(mode), .bank_i(bank), .hw_sub_i(hw_sub),
      .ptr_ld_i(ptr_ld), .ptr_val_i(ptr_val), .sub_ld_i(sub_ld), .sub_val_i(sub_val),
      .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_mask_o(wr_mask),
      .busy_o(busy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: every write on the port must match the head of the queue
   always @(negedge clk) begin
      if (rst_n && !done && wr_en) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R6", "unexpected write addr", int'(wr_addr), -1);
         end else begin
            wr_item_t e;
            e = exp_q.pop_front();
            check(wr_addr == e.addr, "R2-R8", "write addr", int'(wr_addr), int'(e.addr));
            check(wr_mask == e.mask, "R2-R8", "write mask", int'(wr_mask), int'(e.mask));
            check((wr_data & wr_mask) == e.data, "R2-R8", "write data",
                  int'(wr_data & wr_mask), int'(e.data));
         end
      end
   end

   // driver: model the expected writes, then offer the byte
   task automatic send(input logic [7:0] b, input int md, input bit bk,
                       input bit poke, input string req);
      int k, nw, base, cnt;
      k    = md + 1;
      nw   = (8 + k - 1) / k;
      base = (bk && md <= 1) ? 2 : 0;
      for (int s = 0; s < nw; s++) begin
         wr_item_t it;
         it.addr = 6'(m_ptr);
         it.data = '0;
         it.mask = '0;
         for (int j = 0; j < k; j++) begin
            int idx;
            idx = s * k + j;
            if (idx < 8) begin
               it.mask[base + j] = 1'b1;
               it.data[base + j] = b[7 - idx];
            end
         end
         if (m_sub == int'(hw_sub)) exp_q.push_back(it);
         if (m_ptr == DEPTH - 1) begin
            m_ptr = 0;
            m_sub = (m_sub + 1) % 8;
         end else begin
            m_ptr++;
         end
      end
      @(negedge clk);
      byte_d = b; mode = 2'(md); bank = bk; byte_vld = 1'b1;
      @(posedge clk);
      @(negedge clk);
      byte_vld = 1'b0;
      cnt = 0;
      while (busy) begin
         cnt++;
         if (poke && cnt == 1) begin
            // R9 R11: byte and loads offered mid-byte must be ignored
            byte_vld = 1'b1; byte_d = 8'hFF; ptr_ld = 1'b1; ptr_val = 6'd20;
            sub_ld = 1'b1; sub_val = 3'd5;
         end else begin
            byte_vld = 1'b0; ptr_ld = 1'b0; sub_ld = 1'b0;
         end
         @(negedge clk);
      end
      byte_vld = 1'b0; ptr_ld = 1'b0; sub_ld = 1'b0;
      check(cnt == nw, req, "busy cycles (R9)", cnt, nw);
   endtask

   task automatic load(input bit lp, input int pv, input bit ls, input int sv);
      @(negedge clk);
      ptr_ld = lp; ptr_val = 6'(pv); sub_ld = ls; sub_val = 3'(sv);
      @(negedge clk);
      ptr_ld = 1'b0; sub_ld = 1'b0;
      if (lp && pv < DEPTH) m_ptr = pv;
      if (ls) m_sub = sv;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(busy == 1'b0, "R1", "busy in reset", int'(busy), 0);
      check(wr_en == 1'b0, "R1", "wr_en in reset", int'(wr_en), 0);
      check(wr_mask == 4'h0, "R1", "mask in reset", int'(wr_mask), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);

      send(8'hA5, 0, 0, 0, "R1");          // starts at word 0
      send(8'h3C, 0, 0, 0, "R2");
      send(8'h96, 1, 0, 0, "R3");
      send(8'hFF, 2, 0, 0, "R4");          // third word: lane 2 untouched
      send(8'h5A, 3, 0, 0, "R5");
      load(1, 30, 0, 0);                   // R10 legal load
      send(8'hC3, 3, 0, 0, "R10");
      load(1, 45, 0, 0);                   // R10 illegal load ignored
      send(8'h69, 1, 0, 0, "R10");
      load(1, 0, 0, 0);
      send(8'h81, 0, 1, 0, "R8");          // bank: lane 2
      send(8'h7E, 1, 1, 0, "R8");          // bank: lanes 2,3
      send(8'hB4, 3, 1, 0, "R8");          // bank ignored in four-way
      send(8'h2D, 2, 1, 0, "R8");          // bank ignored in three-way
      load(0, 0, 1, 1);                    // R6 mismatch: nothing stored
      send(8'hE7, 0, 0, 0, "R6");
      load(0, 0, 1, 0);
      send(8'h18, 0, 0, 0, "R6");          // pointer advanced past skipped byte
      load(1, 36, 1, 7);                   // R7 wrap inside a static byte
      send(8'hF0, 0, 0, 0, "R7");
      load(1, 38, 1, 0);                   // R7 wrap inside a three-way byte
      send(8'h9C, 2, 0, 0, "R7");
      hw_sub = 3'd1;
      send(8'h4B, 3, 0, 0, "R7");          // counter now 1, matches
      hw_sub = 3'd0;
      load(1, 10, 1, 0);
      send(8'hD2, 0, 0, 1, "R11");         // pokes while busy ignored
      send(8'h33, 1, 0, 0, "R9");          // continues at sequential address
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R6", "pending expected writes", exp_q.size(), 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule